// File: doc/BRIEF.md
# Parallel Pixel to Seven-Bit Serial Lane Converter

The block takes eight 30-bit pixels on every cycle of a slow pixel clock. It turns each pixel into a group of single-ended serial bit streams that are ready for an external differential output buffer. Each pixel belongs to one port. Its 30 bits are spread over five data lanes, and each lane has seven bit slots per pixel period. That gives 35 slots, and the five that no pixel bit fills are sent as zero. A sixth lane per port sends a fixed clock-shaped word. All eight ports share one serializing clock that runs seven times faster than the pixel clock and is edge-aligned with it, so the ports stay in lockstep.

Pixels are mapped and registered on the slow clock. A shared phase counter on the fast clock counts 0 to 6. At phase 0, every lane loads its registered word. It then shifts the word out over the next seven fast cycles, starting with the first slot. One synchronous active-high reset serves both clock domains. It clears the phase counter and drives every serial output low.

Top module: `pixel_lvds_serializer`

## Requirements
- R1: Port p takes its pixel from bits [30p+29:30p] of the 240-bit input. Each port's lanes depend only on that port's pixel.
- R2: Data lane k (k = 0..3) sends pixel bit 7k+s in slot s, and slot 0 is sent first. Data lane 4 sends pixel bit 28 in slot 0 and pixel bit 29 in slot 1.
- R3: Slots 2 to 6 of data lane 4 are always driven to 0.
- R4: In every pixel period after the first one following reset, the clock lane of each port sends slots 0..6 as 1,1,0,0,0,1,1, and all eight clock lanes are equal.
- R5: A pixel present at slow edge n is sent during the seven fast cycles that start at slow edge n+1. Slot s is visible after the s-th fast edge following that slow edge, and each slot lasts exactly one fast cycle.
- R6: While reset is sampled high, every serial output is 0 after the next fast edge. The first pixel period after reset is released sends 0 on all lanes, clock lane included.
- R7: The phase counter is 0 after reset and steps 0,1,...,6,0 on consecutive fast edges. Lanes load only when the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Slow pixel clock, rising edges aligned with every seventh rising edge of clk_ser |
| clk_ser | input | 1 | Fast serial clock, seven times clk_pix |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| pix_in | input | 240 | Eight packed 30-bit pixels, port p at bits [30p+29:30p] |
| ser_data | output | 40 | Serial data lanes, port p lane k at bit 5p+k |
| ser_clk | output | 8 | Serial clock lane of each port, port p at bit p |

## Verification
The bench builds the block with its default parameters: eight ports, 30-bit pixels and a 7:1 ratio. At these values the five unused slots at the end of the last data lane and the full clock pattern are visible. Walking ones, shifted by a different amount per port, reach every bit position of every port. The bench also drives all-ones, all-zero, alternating and random pixels, and asserts reset in the middle of a period. This exercises the cleared first period that follows release and the alignment of the bench's fast-cycle count with the block's phase counter.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  // Number of serial data lanes needed to hold a pixel of pix_w bits.
  function automatic int lanes_for(input int pix_w, input int lane_w);
    return (pix_w + lane_w - 1) / lane_w;
  endfunction

  // Counter width for a phase count of ratio steps.
  function automatic int phase_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper #(
  parameter int PIX_W      = 30,
  parameter int LANE_W     = 7,
  parameter int DATA_LANES = 5
) (
  input  logic [PIX_W-1:0]             pix,
  output logic [DATA_LANES*LANE_W-1:0] words
);

  // Slot s of lane L is word bit LANE_W-1-s (sent first = MSB).
  for (genvar l = 0; l < DATA_LANES; l++) begin : g_lane
    for (genvar s = 0; s < LANE_W; s++) begin : g_slot
      localparam int SRC = l * LANE_W + s;
      if (SRC < PIX_W) begin : g_used
        assign words[l*LANE_W + (LANE_W-1-s)] = pix[SRC];
      end else begin : g_pad
        assign words[l*LANE_W + (LANE_W-1-s)] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lvds_word_stage.sv
module lvds_word_stage #(
  parameter int                PIX_W       = 30,
  parameter int                LANE_W      = 7,
  parameter int                DATA_LANES  = 5,
  parameter logic [LANE_W-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                             clk_pix,
  input  logic                             rst,
  input  logic [PIX_W-1:0]                 pix,
  output logic [(DATA_LANES+1)*LANE_W-1:0] words_q
);

  localparam int DATA_BITS = DATA_LANES * LANE_W;

  logic [DATA_BITS-1:0] mapped;

  lvds_lane_mapper #(
    .PIX_W      (PIX_W),
    .LANE_W     (LANE_W),
    .DATA_LANES (DATA_LANES)
  ) u_map (
    .pix   (pix),
    .words (mapped)
  );

  always_ff @(posedge clk_pix) begin
    if (rst) begin
      words_q <= '0;
    end else begin
      words_q <= {CLK_PATTERN, mapped};
    end
  end

endmodule

// File: rtl/lvds_phase_gen.sv
module lvds_phase_gen #(
  parameter int RATIO = 7,
  parameter int PH_W  = 3
) (
  input  logic            clk_ser,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            load
);

  localparam logic [PH_W-1:0] LAST = PH_W'(RATIO - 1);

  always_ff @(posedge clk_ser) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign load = (phase == '0);

endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
  parameter int W = 7
) (
  input  logic         clk_ser,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         ser
);

  logic [W-1:0] shreg;

  always_ff @(posedge clk_ser) begin
    if (rst) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= word;
    end else begin
      shreg <= {shreg[W-2:0], 1'b0};
    end
  end

  assign ser = shreg[W-1];

endmodule

// File: rtl/pixel_lvds_serializer.sv
module pixel_lvds_serializer #(
  parameter int                NPORTS      = 8,
  parameter int                PIX_W       = 30,
  parameter int                LANE_W      = 7,
  parameter logic [LANE_W-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                                 clk_pix,
  input  logic                                 clk_ser,
  input  logic                                 rst,
  input  logic [NPORTS*PIX_W-1:0]              pix_in,
  output logic [NPORTS*lvds_ser_pkg::lanes_for(PIX_W, LANE_W)-1:0] ser_data,
  output logic [NPORTS-1:0]                    ser_clk
);

  localparam int DATA_LANES = lvds_ser_pkg::lanes_for(PIX_W, LANE_W);
  localparam int PORT_LANES = DATA_LANES + 1;
  localparam int WORD_BITS  = PORT_LANES * LANE_W;
  localparam int PH_W       = lvds_ser_pkg::phase_bits(LANE_W);

  logic [PH_W-1:0] phase_q;
  logic            load;

  lvds_phase_gen #(
    .RATIO (LANE_W),
    .PH_W  (PH_W)
  ) u_phase (
    .clk_ser (clk_ser),
    .rst     (rst),
    .phase   (phase_q),
    .load    (load)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [WORD_BITS-1:0] words_q;

    lvds_word_stage #(
      .PIX_W       (PIX_W),
      .LANE_W      (LANE_W),
      .DATA_LANES  (DATA_LANES),
      .CLK_PATTERN (CLK_PATTERN)
    ) u_stage (
      .clk_pix (clk_pix),
      .rst     (rst),
      .pix     (pix_in[p*PIX_W +: PIX_W]),
      .words_q (words_q)
    );

    for (genvar l = 0; l < PORT_LANES; l++) begin : g_lane
      logic lane_bit;

      lvds_lane_shifter #(
        .W (LANE_W)
      ) u_shift (
        .clk_ser (clk_ser),
        .rst     (rst),
        .load    (load),
        .word    (words_q[l*LANE_W +: LANE_W]),
        .ser     (lane_bit)
      );

      if (l < DATA_LANES) begin : g_data
        assign ser_data[p*DATA_LANES + l] = lane_bit;
      end else begin : g_clk
        assign ser_clk[p] = lane_bit;
      end
    end
  end

endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker #(
  parameter int                NPORTS      = 8,
  parameter int                PIX_W       = 30,
  parameter int                LANE_W      = 7,
  parameter int                DATA_LANES  = 5,
  parameter int                PH_W        = 3,
  parameter logic [LANE_W-1:0] CLK_PATTERN = 7'b1100011
) (
  input logic                           clk_ser,
  input logic                           rst,
  input logic [PH_W-1:0]                phase,
  input logic [NPORTS*DATA_LANES-1:0]   ser_data,
  input logic [NPORTS-1:0]              ser_clk
);

  logic [NPORTS-1:0] last_lane;
  for (genvar p = 0; p < NPORTS; p++) begin : g_last
    assign last_lane[p] = ser_data[p*DATA_LANES + DATA_LANES - 1];
  end

  // R7: phase stays in range, steps by one and wraps after LANE_W-1
  a_r7_phase_range: assert property (@(posedge clk_ser) disable iff (rst)
    phase <= PH_W'(LANE_W - 1));

  a_r7_phase_wrap: assert property (@(posedge clk_ser) disable iff (rst)
    (phase == PH_W'(LANE_W - 1)) |=> (phase == '0));

  a_r7_phase_step: assert property (@(posedge clk_ser) disable iff (rst)
    (phase != PH_W'(LANE_W - 1)) |=> (phase == $past(phase) + 1'b1));

  // R6: reset clears every serial output on the next fast edge
  a_r6_reset_low: assert property (@(posedge clk_ser)
    rst |=> (ser_data == '0 && ser_clk == '0));

  // R4: all ports' clock lanes in lockstep
  a_r4_lanes_lockstep: assert property (@(posedge clk_ser) disable iff (rst)
    (ser_clk == '0 || ser_clk == '1));

  // Slot s is visible while phase == (s+1) mod LANE_W
  for (genvar s = 0; s < LANE_W; s++) begin : g_slot
    localparam logic [PH_W-1:0] PH_OF_SLOT = PH_W'((s + 1) % LANE_W);

    if ((DATA_LANES - 1) * LANE_W + s >= PIX_W) begin : g_pad
      // R3: padded slots of the last data lane are zero
      a_r3_unused_zero: assert property (@(posedge clk_ser) disable iff (rst)
        (phase == PH_OF_SLOT) |-> (last_lane == '0));
    end

    if (CLK_PATTERN[LANE_W-1-s] == 1'b0) begin : g_clk_low
      // R4: low slots of the clock pattern never carry a one
      a_r4_clk_low_slot: assert property (@(posedge clk_ser) disable iff (rst)
        (phase == PH_OF_SLOT) |-> (ser_clk == '0));
    end
  end

endmodule

bind pixel_lvds_serializer lvds_ser_checker #(
  .NPORTS      (NPORTS),
  .PIX_W       (PIX_W),
  .LANE_W      (LANE_W),
  .DATA_LANES  (DATA_LANES),
  .PH_W        (PH_W),
  .CLK_PATTERN (CLK_PATTERN)
) u_chk (
  .clk_ser  (clk_ser),
  .rst      (rst),
  .phase    (phase_q),
  .ser_data (ser_data),
  .ser_clk  (ser_clk)
);

// File: tb/tb_pixel_lvds_serializer.sv
module tb_pixel_lvds_serializer;

  localparam int NP = 8;
  localparam int PW = 30;
  localparam int NL = 5;

  logic             clk_pix = 1'b0;
  logic             clk_ser = 1'b0;
  logic             rst = 1'b1;
  logic [NP*PW-1:0] pix_in = '0;
  logic [NP*NL-1:0] ser_data;
  logic [NP-1:0]    ser_clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state, updated at each rising fast edge
  int               edge_k = 0;
  bit               rst_at_edge = 1'b1;
  bit               prev_v = 1'b0, cur_v = 1'b0;
  logic [NP*PW-1:0] prev_px = '0, cur_px = '0;

  pixel_lvds_serializer dut (
    .clk_pix  (clk_pix),
    .clk_ser  (clk_ser),
    .rst      (rst),
    .pix_in   (pix_in),
    .ser_data (ser_data),
    .ser_clk  (ser_clk)
  );

  function automatic bit exp_data(input logic [PW-1:0] px, input int lane, input int slot);
    if (lane < 4) return px[7*lane + slot];
    if (slot < 2) return px[28 + slot];
    return 1'b0;
  endfunction

  function automatic bit exp_clk(input int slot);
    return (slot <= 1 || slot >= 5);
  endfunction

  task automatic check_outputs();
    for (int p = 0; p < NP; p++) begin
      logic [PW-1:0] px;
      bit idle;
      px   = cur_px[p*PW +: PW];
      idle = rst_at_edge || !cur_v;
      for (int l = 0; l < NL; l++) begin
        bit e;
        e = idle ? 1'b0 : exp_data(px, l, edge_k);
        checks++;
        if (ser_data[p*NL + l] !== e) begin
          errors++;
          if (idle)
            $display("FAIL R6 port %0d lane %0d slot %0d: got %b exp %b", p, l, edge_k, ser_data[p*NL+l], e);
          else if (l == 4 && edge_k >= 2)
            $display("FAIL R3 port %0d lane %0d slot %0d: got %b exp %b", p, l, edge_k, ser_data[p*NL+l], e);
          else
            $display("FAIL R1,R2,R5 port %0d lane %0d slot %0d: got %b exp %b", p, l, edge_k, ser_data[p*NL+l], e);
        end
      end
      begin
        bit ec;
        ec = idle ? 1'b0 : exp_clk(edge_k);
        checks++;
        if (ser_clk[p] !== ec) begin
          errors++;
          $display("FAIL %s port %0d clock lane slot %0d: got %b exp %b",
                   idle ? "R6" : "R4,R7", p, edge_k, ser_clk[p], ec);
        end
      end
    end
  endtask

  // 100 MHz fast clock; slow clock rises on every seventh fast rising edge
  initial begin
    int k;
    k = 0;
    forever begin
      #5;
      rst_at_edge = rst;
      if (k == 0) begin
        cur_v   = prev_v;
        cur_px  = prev_px;
        prev_v  = !rst;
        prev_px = pix_in;
      end
      edge_k  = k;
      clk_ser = 1'b1;
      if (k == 0) clk_pix = 1'b1;
      if (k == 4) clk_pix = 1'b0;
      k = (k + 1) % 7;
      #5;
      clk_ser = 1'b0;
      if (!done) check_outputs();
    end
  end

  task automatic wait_frame_end();
    do @(negedge clk_ser); while (edge_k != 6);
  endtask

  task automatic drive(input logic [NP*PW-1:0] v);
    wait_frame_end();
    pix_in = v;
  endtask

  function automatic logic [NP*PW-1:0] walk(input int n);
    logic [NP*PW-1:0] v;
    for (int p = 0; p < NP; p++) v[p*PW +: PW] = PW'(1) << ((n + p) % PW);
    return v;
  endfunction

  function automatic logic [NP*PW-1:0] rnd();
    logic [NP*PW-1:0] v;
    for (int p = 0; p < NP; p++) v[p*PW +: PW] = PW'($urandom);
    return v;
  endfunction

  initial begin
    // R6: reset held for several pixel periods, outputs checked low each cycle
    repeat (3) wait_frame_end();
    rst = 1'b0;
    pix_in = walk(0);
    // R1, R2, R5: walking ones reach every bit of every port
    for (int n = 1; n < PW; n++) drive(walk(n));
    drive('1);
    drive('0);
    begin
      logic [NP*PW-1:0] alt;
      for (int p = 0; p < NP; p++) alt[p*PW +: PW] = (p % 2) ? 30'h15555555 : 30'h2AAAAAAA;
      drive(alt);
    end
    for (int n = 0; n < 12; n++) drive(rnd());
    // R6: reset asserted in mid-period, released on a period boundary
    do @(negedge clk_ser); while (edge_k != 2);
    rst = 1'b1;
    wait_frame_end();
    wait_frame_end();
    rst = 1'b0;
    pix_in = rnd();
    for (int n = 0; n < 8; n++) drive(rnd());
    drive('0);
    wait_frame_end();
    wait_frame_end();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule